// File: doc/BRIEF.md
# Overflow Alarm Timer

A 16-bit up-counting timer for wake-up and timeout alarms. Software reaches it through a small word-addressed register port with valid, write, address and data signals. The counter advances on a prescaled count enable. That enable comes from one of two sources: every system clock cycle, or each cycle in which a slow fixed-frequency tick input is high. The prescaler divides the selected enable by a power of two.

The counter starts from a programmable start value and climbs to a programmable terminal value. On the next prescaled tick it wraps back to the start value and raises an overflow flag. A level interrupt follows the flag while the interrupt enable is set. Software clears the flag in two steps: it reads the control register with the flag showing 1, then writes 0 to the flag bit.

The flag is a three-state machine:
- `FLG_IDLE`: the flag is clear.
- `FLG_PEND`: the flag is set but software has not yet seen it.
- `FLG_SEEN`: the flag is set and software has read it.

Its transitions:
- `IDLE->PEND` on an overflow.
- `PEND->SEEN` on a control register read.
- `SEEN->IDLE` on a clear write with no overflow in the same cycle.
- `SEEN->SEEN` when an overflow arrives, including when a clear write lands in the same cycle.
- `PEND->PEND` on a clear write, which is ignored in that state.

Top module: `ovf_alarm_timer`

## Requirements
- R1: Reset clears the control register, the counter, the start value and the prescale divider. It sets the terminal value to 0xFFFF and drives irq low.
- R2: Control register fields are prescale select in bits 2:0, clock select in bits 4:3, interrupt enable in bit 6 and overflow flag in bit 7. Clock select 0 or 3 stops the counter. Select 1 counts every system clock cycle. Select 2 counts each cycle in which tick_fixed is high.
- R3: The prescaler produces one count tick per 2^PS selected enables (PS=7 gives 128). A control write that changes PS or the clock select restarts the divider from zero.
- R4: On each tick the counter increments, unless it equals the terminal value; in that case it reloads the start value. With start 0 and terminal N-1, the wrap happens on tick N.
- R5: The overflow flag sets on exactly the tick where the counter wraps from the terminal value to the start value.
- R6: A write of any data to the counter register loads the start value. This load takes precedence over a tick in the same cycle, and that tick produces no overflow.
- R7: The flag clears only through a write with bit 7 at 0 after a control register read that returned the flag as 1. Such a write without the read, and any write with bit 7 at 1, leave the flag unchanged.
- R8: When an overflow and a valid clear write fall in the same cycle, the flag stays set.
- R9: irq is a register equal to the flag ANDed with the interrupt enable, delayed by one cycle. It is active high.
- R10: The control register is at offset 0x00, the counter at 0x04, the terminal value at 0x08 and the start value at 0x4C. Only the low 16 bits of the counter, terminal and start values are kept. Unused bits and unmapped offsets read 0. Read data appears on bus_rdata on the cycle after the read request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_fixed | input | 1 | Slow fixed-frequency count enable (clock select 2) |
| bus_valid | input | 1 | Register access request |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after a read |
| irq | output | 1 | Overflow interrupt, level, active high |

## Verification
The bench drives a set of start, terminal and prescale settings and counts fixed-rate pulses against a behavioural model. It covers a terminal value equal to the start value, counting that stops just short of the wrap, and the largest prescale. A design that wraps one tick early or late, or reloads zero instead of the start value, leaves a wrong count or flag.

Directed tests cover the following corner cases:
- A counter write coinciding with a tick. A design that lets the tick win reads back start value + 1.
- A clear write landing in the same cycle as an overflow. A design that lets the clear win loses the event.
- A clear issued without the prior read. A design that honours it drops irq early.
- A prescale change partway through a divide. A design that keeps the old divider state ticks too soon.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    localparam int OFF_CTRL  = 'h00;
    localparam int OFF_COUNT = 'h04;
    localparam int OFF_TERM  = 'h08;
    localparam int OFF_START = 'h4C;

    localparam int BIT_FLAG = 7;
    localparam int BIT_IE   = 6;

    typedef enum logic [1:0] {
        SRC_OFF  = 2'd0,
        SRC_SYS  = 2'd1,
        SRC_FIX  = 2'd2,
        SRC_RSVD = 2'd3
    } clk_src_e;

    typedef enum logic [1:0] {
        FLG_IDLE = 2'd0,
        FLG_PEND = 2'd1,
        FLG_SEEN = 2'd2
    } flag_state_e;

endpackage

// File: rtl/tmr_prescale.sv
module tmr_prescale #(
    parameter int PS_W = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            src_en_i,
    input  logic [PS_W-1:0] ps_i,
    input  logic            restart_i,
    output logic            tick_o
);
    localparam int DIV_W = (2 ** PS_W) - 1;

    logic [DIV_W-1:0] div_q;
    logic [DIV_W-1:0] lim;

    // terminal divider value: 2^ps - 1 as a thermometer code
    always_comb begin
        lim = '0;
        for (int i = 0; i < DIV_W; i++) begin
            lim[i] = (i < int'(ps_i));
        end
    end

    assign tick_o = src_en_i && (div_q == lim);

    always_ff @(posedge clk) begin
        if (!rst_n || restart_i) begin
            div_q <= '0;
        end else if (src_en_i) begin
            div_q <= tick_o ? '0 : div_q + 1'b1;
        end
    end

    p_restart_r3: assert property (@(posedge clk) disable iff (!rst_n)
        restart_i |=> (div_q == '0));

    p_div_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (div_q <= lim));

endmodule

// File: rtl/tmr_count.sv
module tmr_count #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic             load_i,
    input  logic [CNT_W-1:0] start_i,
    input  logic [CNT_W-1:0] term_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             ovf_o
);
    logic [CNT_W-1:0] cnt_q;
    logic             at_term;

    assign at_term = (cnt_q == term_i);
    assign ovf_o   = tick_i && !load_i && at_term;
    assign cnt_o   = cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load_i) begin
            cnt_q <= start_i;
        end else if (tick_i) begin
            cnt_q <= at_term ? start_i : cnt_q + 1'b1;
        end
    end

    p_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> (cnt_o == $past(start_i)));

    p_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_o |=> (cnt_o == $past(start_i)));

    p_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && !load_i && (cnt_o != term_i)) |=> (cnt_o == $past(cnt_o) + 1'b1));

    p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_i && !load_i) |=> $stable(cnt_o));

endmodule

// File: rtl/tmr_flag.sv
module tmr_flag
    import tmr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic ovf_i,
    input  logic ctrl_rd_i,
    input  logic clr_req_i,
    output logic flag_o
);
    flag_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= FLG_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FLG_IDLE: if (ovf_i)          state_d = FLG_PEND;
            FLG_PEND: if (ctrl_rd_i)      state_d = FLG_SEEN;
            FLG_SEEN: if (ovf_i)          state_d = FLG_SEEN;
                      else if (clr_req_i) state_d = FLG_IDLE;
            default:                      state_d = FLG_IDLE;
        endcase
    end

    assign flag_o = (state_q != FLG_IDLE);

    p_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_i |=> flag_o);

    p_set_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_i && clr_req_i) |=> flag_o);

    p_clear_needs_read_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_o && clr_req_i && !$past(ctrl_rd_i) && (state_q == FLG_PEND)) |=> flag_o);

endmodule

// File: rtl/ovf_alarm_timer.sv
module ovf_alarm_timer
    import tmr_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int PS_W   = 3,
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_fixed,
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq
);
    localparam int CS_LO = PS_W;
    localparam int CS_HI = PS_W + 1;

    logic [PS_W-1:0]   ps_q;
    clk_src_e          src_q;
    logic              ie_q;
    logic [CNT_W-1:0]  term_q;
    logic [CNT_W-1:0]  start_q;
    logic [DATA_W-1:0] rdata_q;
    logic [DATA_W-1:0] rd_mux;
    logic              irq_q;

    logic wr, rd, sel_ctrl, sel_cnt, sel_term, sel_start;
    logic restart, src_en, tick, ovf, flag;
    logic [CNT_W-1:0] cnt;
    logic [PS_W-1:0]  wr_ps;
    clk_src_e         wr_src;
    logic             unused_wbits;

    assign wr        = bus_valid && bus_write;
    assign rd        = bus_valid && !bus_write;
    assign sel_ctrl  = (bus_addr == ADDR_W'(OFF_CTRL));
    assign sel_cnt   = (bus_addr == ADDR_W'(OFF_COUNT));
    assign sel_term  = (bus_addr == ADDR_W'(OFF_TERM));
    assign sel_start = (bus_addr == ADDR_W'(OFF_START));

    assign wr_ps   = bus_wdata[PS_W-1:0];
    assign wr_src  = clk_src_e'(bus_wdata[CS_HI:CS_LO]);
    assign restart = wr && sel_ctrl && ((wr_ps != ps_q) || (wr_src != src_q));

    assign unused_wbits = ^{bus_wdata[DATA_W-1:CNT_W], bus_wdata[5]};

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ps_q    <= '0;
            src_q   <= SRC_OFF;
            ie_q    <= 1'b0;
            term_q  <= {CNT_W{1'b1}};
            start_q <= '0;
        end else if (wr) begin
            if (sel_ctrl) begin
                ps_q  <= wr_ps;
                src_q <= wr_src;
                ie_q  <= bus_wdata[BIT_IE];
            end
            if (sel_term)  term_q  <= bus_wdata[CNT_W-1:0];
            if (sel_start) start_q <= bus_wdata[CNT_W-1:0];
        end
    end

    always_comb begin
        case (src_q)
            SRC_SYS: src_en = 1'b1;
            SRC_FIX: src_en = tick_fixed;
            default: src_en = 1'b0;
        endcase
    end

    tmr_prescale #(.PS_W(PS_W)) u_prescale (
        .clk       (clk),
        .rst_n     (rst_n),
        .src_en_i  (src_en),
        .ps_i      (ps_q),
        .restart_i (restart),
        .tick_o    (tick)
    );

    tmr_count #(.CNT_W(CNT_W)) u_count (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick_i  (tick),
        .load_i  (wr && sel_cnt),
        .start_i (start_q),
        .term_i  (term_q),
        .cnt_o   (cnt),
        .ovf_o   (ovf)
    );

    tmr_flag u_flag (
        .clk       (clk),
        .rst_n     (rst_n),
        .ovf_i     (ovf),
        .ctrl_rd_i (rd && sel_ctrl),
        .clr_req_i (wr && sel_ctrl && !bus_wdata[BIT_FLAG]),
        .flag_o    (flag)
    );

    always_comb begin
        rd_mux = '0;
        if (sel_ctrl) begin
            rd_mux[PS_W-1:0]    = ps_q;
            rd_mux[CS_HI:CS_LO] = src_q;
            rd_mux[BIT_IE]      = ie_q;
            rd_mux[BIT_FLAG]    = flag;
        end else if (sel_cnt) begin
            rd_mux[CNT_W-1:0] = cnt;
        end else if (sel_term) begin
            rd_mux[CNT_W-1:0] = term_q;
        end else if (sel_start) begin
            rd_mux[CNT_W-1:0] = start_q;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata_q <= '0;
            irq_q   <= 1'b0;
        end else begin
            if (rd) rdata_q <= rd_mux;
            irq_q <= flag && ie_q;
        end
    end

    assign bus_rdata = rdata_q;
    assign irq       = irq_q;

    p_irq_r9: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> $past(flag && ie_q));

    p_irq_follow_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && ie_q) |=> irq);

    p_stop_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ((src_q == SRC_OFF) || (src_q == SRC_RSVD)) |-> !tick);

endmodule

// File: tb/ovf_alarm_timer_test.sv
module ovf_alarm_timer_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_fixed = 1'b0;
    logic        bus_valid = 1'b0;
    logic        bus_write = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq;

    int n_chk = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    ovf_alarm_timer uut (
        .clk(clk), .rst_n(rst_n), .tick_fixed(tick_fixed),
        .bus_valid(bus_valid), .bus_write(bus_write), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
    );

    localparam logic [7:0] A_CTRL = 8'h00, A_CNT = 8'h04, A_TERM = 8'h08, A_START = 8'h4C;

    // {ps[2:0], term[15:0], start[15:0], pulses[15:0]}
    localparam int NV = 8;
    localparam logic [50:0] VEC [NV] = '{
        {3'd0, 16'd9,      16'd0,  16'd5},
        {3'd0, 16'd9,      16'd0,  16'd10},
        {3'd0, 16'd9,      16'd0,  16'd9},
        {3'd0, 16'd20,     16'd15, 16'd7},
        {3'd2, 16'd9,      16'd0,  16'd15},
        {3'd3, 16'd3,      16'd1,  16'd40},
        {3'd7, 16'hFFFF,   16'd0,  16'd256},
        {3'd1, 16'd5,      16'd5,  16'd3}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_valid = 1'b0; bus_write = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
        @(negedge clk);
        bus_valid = 1'b0;
        d = bus_rdata;
    endtask

    task automatic pulses(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); tick_fixed = 1'b1;
            @(negedge clk); tick_fixed = 1'b0;
        end
    endtask

    // returns {flag, count} after the given number of prescaled ticks
    function automatic logic [16:0] model(input logic [15:0] term, input logic [15:0] start,
                                          input int ticks);
        logic [15:0] c = start;
        logic f = 1'b0;
        for (int t = 0; t < ticks; t++) begin
            if (c == term) begin c = start; f = 1'b1; end
            else c = c + 16'd1;
        end
        return {f, c};
    endfunction

    task automatic summary;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    initial begin
        #(20 * 150000);
        n_bad++;
        $display("FAIL watchdog expired");
        summary();
        $finish;
    end

    initial begin
        logic [31:0] d;
        logic [16:0] e;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state, R10 map
        chk("R1 irq", {31'd0, irq}, 32'd0);
        rd(A_CTRL, d);  chk("R1 ctrl", d, 32'h0);
        rd(A_CNT, d);   chk("R1 count", d, 32'h0);
        rd(A_TERM, d);  chk("R1 term", d, 32'h0000FFFF);
        rd(A_START, d); chk("R1 start", d, 32'h0);
        rd(8'h10, d);   chk("R10 unmapped", d, 32'h0);
        wr(A_TERM, 32'h1234_5678);
        rd(A_TERM, d);  chk("R10 width", d, 32'h0000_5678);

        // vector table: R3 R4 R5 with fixed tick source
        for (int v = 0; v < NV; v++) begin
            logic [2:0]  ps    = VEC[v][50:48];
            logic [15:0] term  = VEC[v][47:32];
            logic [15:0] start = VEC[v][31:16];
            int          np    = int'(VEC[v][15:0]);
            rd(A_CTRL, d);
            wr(A_CTRL, 32'h0);
            wr(A_TERM, {16'd0, term});
            wr(A_START, {16'd0, start});
            wr(A_CNT, 32'hDEAD);
            wr(A_CTRL, {24'd0, 3'b000, 2'd2, ps});
            pulses(np);
            e = model(term, start, np >> ps);
            rd(A_CNT, d);  chk($sformatf("R4 vec%0d count", v), d, {16'd0, e[15:0]});
            rd(A_CTRL, d); chk($sformatf("R5 vec%0d ctrl", v), d, {24'd0, e[16], 2'b00, 2'd2, ps});
            chk($sformatf("R9 vec%0d irq masked", v), {31'd0, irq}, 32'd0);
        end
        rd(A_CTRL, d);
        wr(A_CTRL, 32'h0);

        // R6 counter write loads start value
        wr(A_START, 32'd7);
        wr(A_CNT, 32'h1234);
        rd(A_CNT, d); chk("R6 load", d, 32'd7);

        // R2 stopped sources
        pulses(4);
        rd(A_CNT, d); chk("R2 select0 stop", d, 32'd7);
        wr(A_CTRL, 32'h18);
        pulses(4);
        rd(A_CNT, d); chk("R2 select3 stop", d, 32'd7);

        // R2 system clock source: 12 edges between start and stop capture
        wr(A_CTRL, 32'h0);
        wr(A_START, 32'd0);
        wr(A_TERM, 32'hFFFF);
        wr(A_CNT, 32'd0);
        wr(A_CTRL, 32'h08);
        repeat (10) @(negedge clk);
        wr(A_CTRL, 32'h0);
        rd(A_CNT, d); chk("R2 system clock", d, 32'd12);

        // R3 divider restart on prescale change
        wr(A_CNT, 32'd0);
        wr(A_CTRL, 32'h12);
        pulses(2);
        wr(A_CTRL, 32'h13);
        pulses(7);
        rd(A_CNT, d); chk("R3 restart", d, 32'd0);
        pulses(1);
        rd(A_CNT, d); chk("R3 divide 8", d, 32'd1);

        // R7 R9 flag, irq and clear protocol
        wr(A_CTRL, 32'h0);
        wr(A_TERM, 32'd2);
        wr(A_CNT, 32'd0);
        wr(A_CTRL, 32'h50);
        pulses(3);
        @(negedge clk);
        chk("R9 irq raised", {31'd0, irq}, 32'd1);
        wr(A_CTRL, 32'h50);
        @(negedge clk);
        chk("R7 clear without read", {31'd0, irq}, 32'd1);
        wr(A_CTRL, 32'hD0);
        @(negedge clk);
        chk("R7 write one", {31'd0, irq}, 32'd1);
        rd(A_CTRL, d); chk("R7 flag readback", d, 32'hD0);
        wr(A_CTRL, 32'h50);
        @(negedge clk);
        chk("R7 irq cleared", {31'd0, irq}, 32'd0);
        rd(A_CTRL, d); chk("R7 flag cleared", d, 32'h50);

        // R8 overflow and clear in the same cycle
        pulses(3);
        rd(A_CTRL, d); chk("R5 flag again", d, 32'hD0);
        pulses(2);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b1; bus_addr = A_CTRL; bus_wdata = 32'h50;
        tick_fixed = 1'b1;
        @(negedge clk);
        bus_valid = 1'b0; bus_write = 1'b0; tick_fixed = 1'b0;
        rd(A_CTRL, d); chk("R8 set wins", d, 32'hD0);
        rd(A_CNT, d);  chk("R4 wrap to start", d, 32'd0);
        wr(A_CTRL, 32'h50);
        rd(A_CTRL, d); chk("R7 clear after read", d, 32'h50);

        // R6 load beats a tick in the same cycle
        pulses(1);
        rd(A_CNT, d); chk("R6 pre", d, 32'd1);
        wr(A_START, 32'd0);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b1; bus_addr = A_CNT; bus_wdata = 32'hFFFF;
        tick_fixed = 1'b1;
        @(negedge clk);
        bus_valid = 1'b0; bus_write = 1'b0; tick_fixed = 1'b0;
        rd(A_CNT, d); chk("R6 load over tick", d, 32'd0);

        summary();
        $finish;
    end

endmodule